// File: doc/BRIEF.md
# GPIO Bank with Atomic Set/Clear Aliases

This block is a bank of general-purpose I/O pins attached to a simple register bus. The bus has write enable, read enable, a byte address, write data and read data. Software picks a direction for each pin. A pin set to output is driven from an output latch. The latch can be loaded as a whole word, or changed bit by bit through two alias registers: one sets bits when they are written as 1, the other clears bits when they are written as 1. With these aliases, single-pin updates need no read-modify-write. The pin side has three ports: a drive value, a drive enable and the raw level seen at the pad.

Pin levels come back to the bus through a synchronizer. Because the bench feeds the pad level into the block, an input-data read returns one of three things: the external level for an input pin, the driven value for a push-pull output pin, or the wired-AND level for an open-drain pin. The parameter `OD_MASK` selects which pins are open-drain. An open-drain pin pulls low when its latch bit is 0 and lets go of the pin when its latch bit is 1.

Register map, by byte address: 0x00 direction, 0x04 output latch, 0x08 set alias, 0x0C clear alias, 0x10 input data (read-only). Any other address reads 0 and ignores writes.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset the direction register reads all ones, the output latch reads 0, `pin_oe` is all zero and `bus_rdata` is 0.
- R2: A direction bit of 1 makes that pin an input, so its `pin_oe` bit is 0. A direction bit of 0 makes it an output: a push-pull pin then has `pin_oe`=1 and `pin_out` equal to its latch bit.
- R3: A write to 0x04 loads the write data into every latch bit whose pin is an output.
- R4: A write to 0x08 sets to 1 each latch bit whose write-data bit is 1 and whose pin is an output. Bits written as 0 are unchanged.
- R5: A write to 0x0C clears to 0 each latch bit whose write-data bit is 1 and whose pin is an output. Bits written as 0 are unchanged.
- R6: Latch bits of pins configured as inputs are not changed by writes to 0x04, 0x08 or 0x0C.
- R7: Reads of 0x04, 0x08 and 0x0C all return the output latch, not the pin level.
- R8: A read of 0x10 returns `pin_in` after a two-flop synchronizer. A level change made between two rising edges is returned by a read captured at the third rising edge after the change. Reads captured at the first two of those edges still return the old level.
- R9: For a push-pull output pin, a read of 0x10 (once the synchronizer has settled) returns the value the block drives.
- R10: For a pin in `OD_MASK` (default: bits 31..24) set as an output, `pin_out` is 0, `pin_oe` is the inverse of its latch bit, and a read of 0x10 returns the wired-AND level. That level is 0 whenever another driver pulls the pin low.
- R11: `bus_rdata` is registered. It updates on the rising edge where `bus_re` is 1 and holds its value otherwise. Unmapped addresses read 0. Writes to 0x10 or to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_out | output | 32 | Value to drive on each pin |
| pin_oe | output | 32 | Drive enable for each pin |
| pin_in | input | 32 | Raw level seen at each pad |

## Verification
A wrong latch bit shows up on `pin_out`/`pin_oe` right after the rising edge of the write that caused it. It shows up on a read of 0x04 one edge after the read strobe. A wrong direction bit flips `pin_oe` in the same cycle. It also corrupts a later read of 0x10 about three edges after the pad level moves. Synchronizer faults show only as a changed read latency, so the bench captures reads at each of the first three edges after a pin change. The bench compares a model of the direction and latch registers, and of the wired pad level, against every read and against the pin outputs after every write.

// File: rtl/gpio_bank_pkg.sv
// gpio_bank_pkg
// Shared constants for the GPIO set/clear bank: bus address width and the
// byte addresses of the five registers. Assumes 32-bit word-aligned registers.
package gpio_bank_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADR_DIR = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_OUT = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_SET = 5'h08;
    localparam logic [ADDR_W-1:0] ADR_CLR = 5'h0C;
    localparam logic [ADDR_W-1:0] ADR_IN  = 5'h10;
endpackage

// File: rtl/gpio_in_sync.sv
// gpio_in_sync
// Multi-stage synchronizer that brings the raw pad levels into the clock
// domain. Assumes each bit is independent (no multi-bit coherency needed).
// STAGES must be at least 1; the default of 2 sets the read latency.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // first stage samples the asynchronous pad level
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= raw_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // each later stage re-times the previous one
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
// gpio_pad_ctrl
// Turns the direction register and output latch into the pin drive value and
// drive enable. Pins flagged in OD_MASK act as open-drain: they only pull
// low, and they release the pin when their latch bit is 1.
// Assumes an external pull-up on open-drain pins.
module gpio_pad_ctrl #(
    parameter int               WIDTH   = 32,
    parameter logic [WIDTH-1:0] OD_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (OD_MASK[i]) begin : g_od
            // open-drain: drive low only while the latch bit is 0
            assign pin_out[i] = 1'b0;
            assign pin_oe[i]  = ~dir_q[i] & ~out_q[i];
        end else begin : g_pp
            // push-pull: drive the latch bit whenever the pin is an output
            assign pin_out[i] = out_q[i];
            assign pin_oe[i]  = ~dir_q[i];
        end
    end

    // R2
    input_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_q) == '0);

    // R10
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_out & OD_MASK) == '0);
endmodule

// File: rtl/gpio_reg_file.sv
// gpio_reg_file
// Register bank behind the bus: direction, output latch with set and clear
// aliases, and the registered read mux. Writes to latch bits of input pins
// are masked. Assumes one bus access per cycle; a read that hits the same
// edge as a write returns the value from before that write.
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  in_sync,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  out_q,
    output logic [WIDTH-1:0]  bus_rdata
);
    logic [WIDTH-1:0] dir_d;
    logic [WIDTH-1:0] out_d;
    logic [WIDTH-1:0] wr_bits;
    logic [WIDTH-1:0] rd_mux;
    logic             latch_addr;
    logic             mapped;

    // write data restricted to pins that are currently outputs
    assign wr_bits = bus_wdata & ~dir_q;

    // next-state decode for direction and output latch
    always_comb begin
        dir_d = dir_q;
        out_d = out_q;
        if (bus_we) begin
            unique case (bus_addr)
                ADR_DIR: dir_d = bus_wdata;
                ADR_OUT: out_d = (out_q & dir_q) | wr_bits;
                ADR_SET: out_d = out_q | wr_bits;
                ADR_CLR: out_d = out_q & ~wr_bits;
                default: ;
            endcase
        end
    end

    // state update with synchronous reset: all inputs, latch cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
            out_q <= '0;
        end else begin
            dir_q <= dir_d;
            out_q <= out_d;
        end
    end

    // classify the read address
    assign latch_addr = (bus_addr == ADR_OUT) || (bus_addr == ADR_SET) ||
                        (bus_addr == ADR_CLR);
    assign mapped     = latch_addr || (bus_addr == ADR_DIR) || (bus_addr == ADR_IN);

    // read mux: latch aliases share one source
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADR_DIR)     rd_mux = dir_q;
        else if (latch_addr)         rd_mux = out_q;
        else if (bus_addr == ADR_IN) rd_mux = in_sync;
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    // R4
    set_bits_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_SET) |=>
            ((out_q & $past(bus_wdata & ~dir_q)) == $past(bus_wdata & ~dir_q)));

    // R5
    clr_bits_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_CLR) |=>
            ((out_q & $past(bus_wdata & ~dir_q)) == '0));

    // R6
    input_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((out_q ^ $past(out_q)) & $past(dir_q)) == '0));

    // R7
    latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && latch_addr) |=> (bus_rdata == $past(out_q)));

    // R8
    in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADR_IN) |=> (bus_rdata == $past(in_sync)));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !mapped) |=> (bus_rdata == '0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_re) |=> $stable(bus_rdata));
endmodule

// File: rtl/gpio_setclr_bank.sv
// gpio_setclr_bank
// Top of the GPIO bank: register file, pad drive control and input
// synchronizer. Assumes pin_in carries the resolved pad level, including
// this block's own drive and any wired-AND on open-drain pins.
module gpio_setclr_bank
    import gpio_bank_pkg::*;
#(
    parameter int                 N_PINS     = 32,
    parameter int                 SYNC_DEPTH = 2,
    parameter logic [N_PINS-1:0]  OD_MASK    = 32'hFF00_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    input  logic [N_PINS-1:0] pin_in
);
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] out_q;
    logic [N_PINS-1:0] in_sync;

    gpio_reg_file #(.WIDTH(N_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .in_sync   (in_sync),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .bus_rdata (bus_rdata)
    );

    gpio_pad_ctrl #(.WIDTH(N_PINS), .OD_MASK(OD_MASK)) u_pad (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    gpio_in_sync #(.WIDTH(N_PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (in_sync)
    );
endmodule

// File: tb/gpio_setclr_bank_test.sv
`timescale 1ns/1ps
module gpio_setclr_bank_test;
    localparam logic [31:0] OD = 32'hFF00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, pin_out, pin_oe, pin_in;
    logic [31:0] ext = '1;          // external level; 0 = another driver pulls low

    int unsigned n_tests = 0, n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] dir_m = '1, out_m = '0;   // bench model

    always #10 clk = ~clk;  // 50 MHz

    // pad model: own drive or external level, wired-AND on open-drain pins
    assign pin_in = ((pin_oe & pin_out) | (~pin_oe & ext)) & (ext | ~OD);

    gpio_setclr_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    function automatic logic [31:0] exp_oe();
        return ~dir_m & ~(OD & out_m);
    endfunction
    function automatic logic [31:0] exp_po();
        return out_m & ~OD;
    endfunction
    function automatic logic [31:0] exp_in();
        logic [31:0] oe = exp_oe();
        return ((oe & exp_po()) | (~oe & ext)) & (ext | ~OD);
    endfunction
    function automatic void model_write(logic [4:0] a, logic [31:0] d);
        logic [31:0] m = d & ~dir_m;
        case (a)
            5'h00: dir_m = d;
            5'h04: out_m = (out_m & dir_m) | m;
            5'h08: out_m = out_m | m;
            5'h0C: out_m = out_m & ~m;
            default: ;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] v);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_pins(string req);
        check({req, " pin_oe"}, pin_oe, exp_oe());
        check({req, " pin_out"}, pin_out & exp_oe(), exp_po() & exp_oe());
    endtask

    // watchdog
    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual=not finished expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0, d;
        void'($urandom(32'd20250611));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        rd(5'h00, v); check("R1 dir", v, 32'hFFFF_FFFF);
        rd(5'h04, v); check("R1 latch", v, 32'h0);

        // R6 writes ignored while all pins are inputs
        wr(5'h04, 32'hFFFF_FFFF); wr(5'h08, 32'h1234_5678);
        rd(5'h04, v); check("R6 all-input latch", v, 32'h0);

        // R2 low half outputs
        wr(5'h00, 32'hFFFF_0000);
        check_pins("R2");
        check("R2 oe value", pin_oe, 32'h0000_FFFF);

        // R3 whole-word write, R6 masking of input half
        wr(5'h04, 32'hA5A5_A5A5);
        rd(5'h04, v); check("R3 latch", v, 32'h0000_A5A5);
        check("R3 pin_out", pin_out[15:0], 16'hA5A5);

        // R4 set alias
        wr(5'h08, 32'h00FF_00F0);
        rd(5'h04, v); check("R4 set", v, 32'h0000_A5F5);
        // R5 clear alias
        wr(5'h0C, 32'hFFFF_0081);
        rd(5'h04, v); check("R5 clear", v, 32'h0000_A574);

        // R7 aliases read latch, not pins
        ext = 32'h0F0F_0F0F;
        idle(3);
        rd(5'h08, v); check("R7 set alias read", v, 32'h0000_A574);
        rd(5'h0C, v); check("R7 clear alias read", v, 32'h0000_A574);
        // R9 input data shows driven value on outputs, ext on inputs
        rd(5'h10, v); check("R9 input data", v, {16'h0F0F, 16'hA574});

        // R8 synchronizer latency
        v0 = exp_in();
        ext = 32'hF0F0_0F0F ^ 32'h0FF0_0000;
        rd(5'h10, v); check("R8 edge1 old", v, v0);
        rd(5'h10, v); check("R8 edge2 old", v, v0);
        rd(5'h10, v); check("R8 edge3 new", v, exp_in());

        // R10 open-drain upper byte
        ext = '1;
        wr(5'h00, 32'h0000_0000);
        wr(5'h04, 32'h5A00_0000);
        check("R10 od oe", pin_oe[31:24], 8'hA5);
        check("R10 od pin_out", pin_out[31:24], 8'h00);
        idle(3);
        rd(5'h10, v); check("R10 released reads high", v[31:24], 8'h5A);
        ext = 32'hFDFF_FFFF;   // pull bit 25 low; latch bit is 1 (released)
        idle(3);
        rd(5'h10, v); check("R10 wired-AND low", v[31:24], 8'h58);

        // R11 unmapped / read-only / hold
        rd(5'h14, v); check("R11 unmapped read", v, 32'h0);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h04, v); check("R11 write to 0x10 ignored", v, 32'h5A00_0000);
        rd(5'h00, v); check("R11 dir unchanged", v, 32'h0);
        idle(2);
        check("R11 rdata held", bus_rdata, 32'h0);
        rd(5'h04, v);
        wr(5'h08, 32'h0000_0001);
        check("R11 rdata held after write", bus_rdata, 32'h5A00_0000);

        // constrained random against the model
        for (int it = 0; it < 1500; it++) begin
            int op = int'($urandom % 8);
            d = $urandom;
            case (op)
                0: wr(5'h00, d);
                1: wr(5'h04, d);
                2: begin wr(5'h08, d); check_pins("R4 random"); end
                3: begin wr(5'h0C, d); check_pins("R5 random"); end
                4: begin
                    logic [4:0] a = (($urandom % 3) == 0) ? 5'h04 :
                                    (($urandom % 2) == 0) ? 5'h08 : 5'h0C;
                    rd(a, v); check("R7 random latch read", v, out_m);
                end
                5: begin
                    ext = $urandom | $urandom;
                    idle(3);
                    rd(5'h10, v); check("R8 R9 R10 random input read", v, exp_in());
                end
                6: begin rd(5'h00, v); check("R2 random dir read", v, dir_m); end
                default: begin
                    rd(5'h14 + 5'(($urandom % 3) * 4), v);
                    check("R11 random unmapped", v, 32'h0);
                end
            endcase
            if (op <= 1) check_pins("R3 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule